// File: doc/BRIEF.md
# Dirty-Granule Write-Back Tracker

This block keeps one dirty bit for each aligned 16-byte granule (four 32-bit words) of a small local data memory. A store of any size into a granule marks the whole granule dirty. A DMA pass over that granule marks it clean again.

A DMA engine starts a pass with a byte start address, a byte length, a full-transfer flag, a target select (data or instruction memory) and a direction. The tracker then walks the covered granules in ascending order, one granule per clock. For each granule that has to move, it emits the granule's base address. When the walk ends it raises a one-cycle done pulse.

Clean granules are skipped only in one case: the target is the data memory, the direction is local-to-external, and full transfer is off. In every other case each covered granule is emitted.

Top module: `dirty_granule_tracker`

## Requirements
- R1: After reset no granule is dirty and busy_o, xfer_vld_o and done_o are 0.
- R2: A store at any byte address marks dirty the whole granule holding that byte. The granule index is address bits [9:4].
- R3: For a data-memory, local-to-external pass with full transfer off, only dirty granules are emitted. Clean granules are skipped. The walk visits granules in ascending order at one granule per cycle.
- R4: Each emitted address is the granule base, with bits [3:0] equal to 0. A granule only partly covered by the range is emitted as a whole granule.
- R5: With full transfer set, every covered granule is emitted whatever its dirty state.
- R6: When the target is the instruction memory, every covered granule is emitted whatever the full-transfer flag. The data-memory dirty bits are left unchanged.
- R7: For an external-to-local pass, every covered granule is emitted.
- R8: Every granule visited by a data-memory pass is clean afterwards, whether it was emitted or skipped.
- R9: A store into the granule being visited in the same cycle leaves that granule dirty.
- R10: done_o is a one-cycle pulse. It comes on the same edge as the result of the last granule, and busy_o is 0 at that time.
- R11: A zero length emits nothing and pulses done_o on the edge that takes the start.
- R12: A start request while busy is ignored, and the pass in progress continues unchanged.
- R13: A range that runs past the top of the memory is clipped at the last granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_vld_i | input | 1 | Store to the local data memory this cycle |
| st_addr_i | input | 10 | Byte address of the store |
| start_i | input | 1 | Start a pass (taken only when idle) |
| start_addr_i | input | 10 | Byte start address of the pass |
| len_i | input | 11 | Length of the pass in bytes |
| full_i | input | 1 | Full transfer: emit every granule |
| instr_tgt_i | input | 1 | 1 = instruction memory target, 0 = data memory |
| to_ext_i | input | 1 | 1 = local-to-external, 0 = external-to-local |
| busy_o | output | 1 | Pass in progress |
| xfer_vld_o | output | 1 | A granule is emitted this cycle |
| xfer_addr_o | output | 10 | Base byte address of the emitted granule |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
Call the edge that takes start_i E0. The decision for the k-th covered granule (k from 0) appears on xfer_vld_o and xfer_addr_o just after edge E0+k+1. For a pass of N granules, done_o comes just after edge E0+N, which is E0 itself when N is 0. A store sampled on the same edge as a visit overrides that visit's clean. The bench drives and samples at falling edges and counts those edges from the start request, so it checks each granule's decision and the done pulse in the exact cycle they are due. It also checks one cycle later that done_o has fallen. Dirty state is read back only through later filtered passes.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
  typedef struct packed {
    logic skip_clean;  // filter clean granules
    logic clean_en;    // pass clears data-memory dirty bits
  } mode_t;
endpackage

// File: rtl/dgt_dirty_array.sv
module dgt_dirty_array #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_vld_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_vld_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_dirty_o
);
  localparam int unsigned NUM_GRAN = 1 << IDX_W;

  logic [NUM_GRAN-1:0] dirty_q;

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_bit
    // store wins over a clean in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         dirty_q[g] <= 1'b0;
      else if (set_vld_i && set_idx_i == IDX_W'(g))        dirty_q[g] <= 1'b1;
      else if (clr_vld_i && clr_idx_i == IDX_W'(g))        dirty_q[g] <= 1'b0;
    end
  end

  assign rd_dirty_o = dirty_q[rd_idx_i];

  AST_STORE_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_i |=> dirty_q[$past(set_idx_i)]);  // R9
  AST_VISIT_CLEANS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_vld_i && !(set_vld_i && set_idx_i == clr_idx_i) |=> !dirty_q[$past(clr_idx_i)]);  // R8
endmodule

// File: rtl/dgt_range.sv
module dgt_range #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned GRAN_LSB = 4,
  parameter int unsigned IDX_W    = ADDR_W - GRAN_LSB
) (
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W:0]   len_i,
  output logic [IDX_W-1:0]  first_o,
  output logic [IDX_W-1:0]  last_o,
  output logic              empty_o
);
  logic [ADDR_W+1:0] end_w;

  always_comb begin
    end_w   = {2'b00, start_addr_i} + {1'b0, len_i} - (ADDR_W+2)'(1);
    empty_o = (len_i == '0);
    first_o = IDX_W'(start_addr_i >> GRAN_LSB);
    // clip at the top granule when the range runs off the memory
    if (end_w[ADDR_W+1:ADDR_W] != 2'b00) last_o = '1;
    else                                 last_o = IDX_W'(end_w >> GRAN_LSB);
  end
endmodule

// File: rtl/dgt_walker.sv
module dgt_walker
  import dgt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned GRAN_LSB = 4,
  parameter int unsigned IDX_W    = ADDR_W - GRAN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  first_i,
  input  logic [IDX_W-1:0]  last_i,
  input  logic              empty_i,
  input  mode_t             mode_i,
  input  logic              dirty_i,
  output logic [IDX_W-1:0]  cur_o,
  output logic              clr_vld_o,
  output logic              busy_o,
  output logic              xfer_vld_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              done_o
);
  logic              busy_q, xfer_vld_q, done_q;
  logic [IDX_W-1:0]  cur_q, last_q;
  logic [ADDR_W-1:0] xfer_addr_q;
  mode_t             mode_q;
  logic              issue;

  assign issue     = busy_q && (!mode_q.skip_clean || dirty_i);
  assign clr_vld_o = busy_q && mode_q.clean_en;
  assign cur_o     = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      xfer_vld_q  <= 1'b0;
      done_q      <= 1'b0;
      cur_q       <= '0;
      last_q      <= '0;
      xfer_addr_q <= '0;
      mode_q      <= '0;
    end else begin
      xfer_vld_q <= 1'b0;
      done_q     <= 1'b0;
      if (busy_q) begin
        xfer_vld_q <= issue;
        if (issue) xfer_addr_q <= {cur_q, {GRAN_LSB{1'b0}}};
        if (cur_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cur_q <= cur_q + IDX_W'(1);
        end
      end else if (start_i) begin
        if (empty_i) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cur_q  <= first_i;
          last_q <= last_i;
          mode_q <= mode_i;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign xfer_vld_o  = xfer_vld_q;
  assign xfer_addr_o = xfer_addr_q;
  assign done_o      = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);  // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);  // R10
  AST_FULL_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !mode_q.skip_clean |=> xfer_vld_q);  // R5
  AST_SKIP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && mode_q.skip_clean && !dirty_i |=> !xfer_vld_q);  // R3
  AST_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cur_q != last_q |=> cur_q == $past(cur_q) + IDX_W'(1));  // R3
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && cur_q != last_q |=> $stable(mode_q) && $stable(last_q));  // R12
endmodule

// File: rtl/dirty_granule_tracker.sv
module dirty_granule_tracker
  import dgt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned GRAN_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_vld_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W:0]   len_i,
  input  logic              full_i,
  input  logic              instr_tgt_i,
  input  logic              to_ext_i,
  output logic              busy_o,
  output logic              xfer_vld_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              done_o
);
  localparam int unsigned GRAN_LSB = $clog2(WORD_BYTES * GRAN_WORDS);
  localparam int unsigned IDX_W    = ADDR_W - GRAN_LSB;

  logic [IDX_W-1:0] st_idx, first, last, cur;
  logic             empty, dirty, clr_vld;
  mode_t            mode;

  assign st_idx          = IDX_W'(st_addr_i >> GRAN_LSB);
  assign mode.skip_clean = to_ext_i && !full_i && !instr_tgt_i;
  assign mode.clean_en   = !instr_tgt_i;

  dgt_range #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .IDX_W(IDX_W)) u_range (
    .start_addr_i(start_addr_i),
    .len_i       (len_i),
    .first_o     (first),
    .last_o      (last),
    .empty_o     (empty)
  );

  dgt_dirty_array #(.IDX_W(IDX_W)) u_dirty (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_vld_i (st_vld_i),
    .set_idx_i (st_idx),
    .clr_vld_i (clr_vld),
    .clr_idx_i (cur),
    .rd_idx_i  (cur),
    .rd_dirty_o(dirty)
  );

  dgt_walker #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .IDX_W(IDX_W)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .first_i    (first),
    .last_i     (last),
    .empty_i    (empty),
    .mode_i     (mode),
    .dirty_i    (dirty),
    .cur_o      (cur),
    .clr_vld_o  (clr_vld),
    .busy_o     (busy_o),
    .xfer_vld_o (xfer_vld_o),
    .xfer_addr_o(xfer_addr_o),
    .done_o     (done_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !busy_o && !done_o);  // R1
  AST_EMIT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_o |-> xfer_addr_o[GRAN_LSB-1:0] == '0);  // R4
endmodule

// File: tb/sim_dirty_granule_tracker.sv
`timescale 1ns/1ps
module sim_dirty_granule_tracker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_vld_i = 1'b0;
  logic [9:0]  st_addr_i = '0;
  logic        start_i = 1'b0;
  logic [9:0]  start_addr_i = '0;
  logic [10:0] len_i = '0;
  logic        full_i = 1'b0, instr_tgt_i = 1'b0, to_ext_i = 1'b0;
  logic        busy_o, xfer_vld_o, done_o;
  logic [9:0]  xfer_addr_o;

  int   n_run = 0, n_fail = 0;
  logic finished = 1'b0;
  logic [63:0] mdl = '0;

  always #2 clk_i = ~clk_i;

  dirty_granule_tracker u0 (.*);

  // {run, addr, len, full, instr, to_ext}
  localparam logic [24:0] VEC [14] = '{
    {1'b0, 10'h013, 11'h000, 3'b000},  // R2 store g1
    {1'b0, 10'h05E, 11'h000, 3'b000},  // R2 store g5
    {1'b0, 10'h040, 11'h000, 3'b000},  // R2 store g4
    {1'b1, 10'h000, 11'h080, 3'b001},  // R3 emits g1,g4,g5
    {1'b1, 10'h000, 11'h080, 3'b001},  // R8 nothing left
    {1'b0, 10'h025, 11'h000, 3'b000},
    {1'b1, 10'h028, 11'h004, 3'b001},  // R4 partial granule g2
    {1'b1, 10'h100, 11'h040, 3'b101},  // R5 full
    {1'b0, 10'h3F1, 11'h000, 3'b000},
    {1'b1, 10'h3C0, 11'h040, 3'b011},  // R6 instruction target
    {1'b1, 10'h3C0, 11'h040, 3'b001},  // R6 dirty kept: g63 only
    {1'b0, 10'h200, 11'h000, 3'b000},
    {1'b1, 10'h200, 11'h020, 3'b000},  // R7 inbound
    {1'b1, 10'h200, 11'h020, 3'b001}   // R8 cleaned by inbound pass
  };

  task automatic chk(input string rq, input logic ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic store(input logic [9:0] a);
    @(negedge clk_i);
    st_vld_i = 1'b1; st_addr_i = a;
    @(negedge clk_i);
    st_vld_i = 1'b0;
    mdl[int'(a) >> 4] = 1'b1;
  endtask

  task automatic run(input logic [9:0] sa, input logic [10:0] ln, input logic fu, ins, dout,
                     input int st_at, input logic [9:0] st_a, input int rs_at, input string rq);
    int first = int'(sa) >> 4;
    int endb  = int'(sa) + int'(ln) - 1;
    int last  = (endb > 1023) ? 63 : (endb >> 4);
    int n     = (ln == 0) ? 0 : last - first + 1;
    bit [63:0] expi = '0;
    for (int k = 0; k < n; k++) begin
      expi[k] = !(dout && !fu && !ins) || mdl[first + k];
      if (!ins) mdl[first + k] = 1'b0;
    end
    if (st_at >= 0) mdl[int'(st_a) >> 4] = 1'b1;
    @(negedge clk_i);
    start_addr_i = sa; len_i = ln; full_i = fu; instr_tgt_i = ins; to_ext_i = dout;
    start_i = 1'b1;
    for (int j = 0; j <= n; j++) begin
      @(negedge clk_i);
      start_i = 1'b0; st_vld_i = 1'b0;
      if (j >= 1) begin
        chk(rq, xfer_vld_o == expi[j-1], int'(xfer_vld_o), int'(expi[j-1]));
        if (expi[j-1]) chk(rq, int'(xfer_addr_o) == (first + j - 1) << 4,
                           int'(xfer_addr_o), (first + j - 1) << 4);
      end
      chk((j == n) ? "R10" : rq, done_o == (j == n), int'(done_o), int'(j == n));
      if (j < n && j == st_at) begin st_vld_i = 1'b1; st_addr_i = st_a; end
      if (j < n && j == rs_at) begin
        start_i = 1'b1; start_addr_i = '0; len_i = 11'h400; full_i = 1'b1;
      end
    end
    @(negedge clk_i);
    start_i = 1'b0; st_vld_i = 1'b0;
    chk("R10", !done_o && !busy_o && !xfer_vld_o, int'({done_o, busy_o, xfer_vld_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", !busy_o && !xfer_vld_o && !done_o, int'({busy_o, xfer_vld_o, done_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", !busy_o && !xfer_vld_o && !done_o, int'({busy_o, xfer_vld_o, done_o}), 0);
    run(10'h000, 11'h400, 1'b0, 1'b0, 1'b1, -1, '0, -1, "R1");  // all clean after reset

    for (int i = 0; i < 14; i++) begin
      logic [24:0] v = VEC[i];
      string rq = v[1] ? "R6" : !v[0] ? "R7" : v[2] ? "R5" : "R3";
      if (!v[24]) store(v[23:14]);
      else run(v[23:14], v[13:3], v[2], v[1], v[0], -1, '0, -1, rq);
    end

    store(10'h30F);                                             // last byte of g48
    run(10'h300, 11'h030, 1'b0, 1'b0, 1'b1, -1, '0, -1, "R2");
    run(10'h050, 11'h000, 1'b0, 1'b0, 1'b1, -1, '0, -1, "R11");
    run(10'h080, 11'h040, 1'b1, 1'b0, 1'b1, 2, 10'h0A4, 1, "R12");  // store g10 on its visit
    run(10'h080, 11'h040, 1'b0, 1'b0, 1'b1, -1, '0, -1, "R9");
    store(10'h3F8);
    run(10'h3F8, 11'h100, 1'b0, 1'b0, 1'b1, -1, '0, -1, "R13");
    run(10'h3F0, 11'h7FF, 1'b1, 1'b0, 1'b1, -1, '0, -1, "R13");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule